// File: doc/BRIEF.md
# Configurable Output Logic Cell Bank

This block is the output stage of a programmable sum-of-products logic device. It holds a bank of identical cells. Each cell receives one sum-of-products term from the logic array and an output-enable term of its own. All cells share a clock, an asynchronous clear term and a synchronous preset term. A two-bit mode per cell picks between a registered path through a D flip-flop and a combinatorial path that bypasses it, and between active-high and active-low pin polarity. Each cell drives a bidirectional pin through a tristate buffer and returns a feedback bit to the array. In registered mode the feedback is the flip-flop state. In combinatorial mode the feedback is the resolved pin value, so a pin whose driver is off can serve as an input.

The per-cell modes come from a serial configuration register. While `cfg_load` is high, one bit enters on each clock. When `cfg_load` is seen low again, the whole new pattern is applied in a single step. A small controller with two states sequences the load. `CFG_IDLE` holds the applied pattern. The transition *start* (`cfg_load` high) shifts the first bit and enters `CFG_SHIFT`. In `CFG_SHIFT`, the transition *continue* (`cfg_load` high) shifts one more bit. The transition *commit* (`cfg_load` low) copies the shadow pattern to the applied pattern and returns to `CFG_IDLE`. After power-on reset every cell reads as erased, which means combinatorial and active high.

Top module: `pld_macrocell_bank`

## Requirements
- R1: After `por_n` is released, every cell is in mode `{S1,S0}`=11 (combinatorial, active high), and every flip-flop holds 0.
- R2: In registered modes the flip-flop loads `sop` on each rising clock edge when neither clear nor preset is active. The pin changes only at that edge: it shows Q for mode 01 and the inverse of Q for mode 00.
- R3: In combinatorial modes the pin follows `sop` without waiting for a clock edge. The pin shows `sop` for mode 11 and its inverse for mode 10.
- R4: In registered modes `fb` equals the flip-flop state. This holds whatever the pin carries and whatever the value of `oe`.
- R5: In combinatorial modes `fb` equals the pin value. When `oe` is low, this is the value an external source drives onto the pin.
- R6: A cell drives its pin only while its `oe` bit is high. Otherwise the pin is released to high impedance and an external driver sets its level.
- R7: `clr_term` high clears every flip-flop at once, without a clock edge, and holds them clear while it stays high.
- R8: `preset_term` high sets every flip-flop to 1 at the next rising edge. When `clr_term` and `preset_term` are both high, the clear wins.
- R9: Cell i takes its mode from bits [2i+1:2i] of the configuration pattern, with S1 in bit 2i+1 and S0 in bit 2i. Bits are shifted in bit 0 first, so cell 0 comes first and S0 comes before S1. The applied modes do not change while bits are shifting. The new pattern takes effect at the first rising edge at which `cfg_load` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; flip-flops and the configuration register update on its rising edge |
| por_n | input | 1 | Active-low power-on reset; sets all cells to the erased mode and clears the flip-flops |
| clr_term | input | 1 | Asynchronous clear term for all flip-flops, active high |
| preset_term | input | 1 | Synchronous preset term for all flip-flops, active high |
| sop | input | NUM_CELLS | Sum-of-products data term, one bit per cell |
| oe | input | NUM_CELLS | Output-enable term, one bit per cell; high drives the pin |
| cfg_load | input | 1 | High while configuration bits are being shifted in; the pattern is applied when it falls |
| cfg_sdi | input | 1 | Serial configuration data, one bit per clock while `cfg_load` is high |
| io_pin | inout | NUM_CELLS | Bidirectional pins |
| fb | output | NUM_CELLS | Feedback bits returned to the logic array |

## Verification
A wrong flip-flop state shows on the pin of any cell in a registered mode at once. It also shows on `fb` whatever `oe` is, so a capture, clear or preset error appears within one clock of the edge that caused it, and an error of the asynchronous clear appears before any edge. A wrong applied mode shows as a wrong polarity, a wrong timing of the pin (at the edge or immediately), or the wrong feedback source. The bench gives every cell each of the four modes, so a swapped bit or a swapped cell in the configuration pattern changes a pin within one check. A commit made one cycle early or late is caught by checks taken just before and just after the commit edge.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MC_REG_LOW   = 2'b00,
        MC_REG_HIGH  = 2'b01,
        MC_COMB_LOW  = 2'b10,
        MC_COMB_HIGH = 2'b11
    } mc_mode_e;

    typedef enum logic {
        CFG_IDLE  = 1'b0,
        CFG_SHIFT = 1'b1
    } cfg_state_e;

    localparam logic [1:0] MC_ERASED = 2'b11;

endpackage

// File: rtl/pld_cfg_loader.sv
module pld_cfg_loader
    import pld_mc_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    localparam int CFG_W = 2 * NUM_CELLS
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_en,
    input  logic             sdi,
    output logic [CFG_W-1:0] cfg_q
);

    cfg_state_e       state_q;
    cfg_state_e       state_d;
    logic [CFG_W-1:0] shadow_q;
    logic             do_shift;
    logic             do_commit;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-state actions
    always_comb begin
        state_d   = state_q;
        do_shift  = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            CFG_IDLE: begin
                if (load_en) begin
                    do_shift = 1'b1;
                    state_d  = CFG_SHIFT;
                end
            end
            CFG_SHIFT: begin
                if (load_en) begin
                    do_shift = 1'b1;
                end else begin
                    do_commit = 1'b1;
                    state_d   = CFG_IDLE;
                end
            end
        endcase
    end

    // Shadow and applied pattern; the erased state reads as all ones
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            shadow_q <= {NUM_CELLS{MC_ERASED}};
            cfg_q    <= {NUM_CELLS{MC_ERASED}};
        end else begin
            if (do_shift) begin
                shadow_q <= {sdi, shadow_q[CFG_W-1:1]};
            end
            if (do_commit) begin
                cfg_q <= shadow_q;
            end
        end
    end

    // R9: applied pattern is untouched while bits are arriving
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        load_en |=> $stable(cfg_q))
        else $error("p_cfg_hold_r9");

    // R9: commit copies the shadow pattern as it stood at the falling load
    p_cfg_commit_r9: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == CFG_SHIFT && !load_en) |=> (cfg_q == $past(shadow_q)))
        else $error("p_cfg_commit_r9");

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_mc_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     clr_term,
    input  logic     preset_term,
    input  logic     sop,
    input  logic     oe,
    input  mc_mode_e mode,
    input  logic     pin_in,
    output logic     drv_val,
    output logic     drv_en,
    output logic     fb
);

    logic q_r;
    logic is_reg;
    logic act_high;
    logic path;

    // Storage flip-flop: clear beats preset, preset beats data
    always_ff @(posedge clk or negedge por_n or posedge clr_term) begin
        if (!por_n) begin
            q_r <= 1'b0;
        end else if (clr_term) begin
            q_r <= 1'b0;
        end else if (preset_term) begin
            q_r <= 1'b1;
        end else begin
            q_r <= sop;
        end
    end

    // Mode decode, data path, polarity and feedback selection
    always_comb begin
        unique case (mode)
            MC_REG_LOW:   begin is_reg = 1'b1; act_high = 1'b0; end
            MC_REG_HIGH:  begin is_reg = 1'b1; act_high = 1'b1; end
            MC_COMB_LOW:  begin is_reg = 1'b0; act_high = 1'b0; end
            MC_COMB_HIGH: begin is_reg = 1'b0; act_high = 1'b1; end
        endcase
        path    = is_reg ? q_r : sop;
        drv_val = act_high ? path : ~path;
        drv_en  = oe;
        fb      = is_reg ? q_r : pin_in;
    end

    // R2: plain capture of the data term
    p_capture_r2: assert property (@(posedge clk) disable iff (!por_n || clr_term)
        (!preset_term) |=> (q_r == $past(sop)))
        else $error("p_capture_r2");

    // R7: the flip-flop stays clear while the clear term is high
    p_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
        clr_term |-> !q_r)
        else $error("p_clear_r7");

    // R8: preset sets the flip-flop at the next edge
    p_preset_r8: assert property (@(posedge clk) disable iff (!por_n || clr_term)
        preset_term |=> q_r)
        else $error("p_preset_r8");

endmodule

// File: rtl/pld_macrocell_bank.sv
module pld_macrocell_bank
    import pld_mc_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    localparam int CFG_W = 2 * NUM_CELLS
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 clr_term,
    input  logic                 preset_term,
    input  logic [NUM_CELLS-1:0] sop,
    input  logic [NUM_CELLS-1:0] oe,
    input  logic                 cfg_load,
    input  logic                 cfg_sdi,
    inout  wire  [NUM_CELLS-1:0] io_pin,
    output logic [NUM_CELLS-1:0] fb
);

    logic [CFG_W-1:0]     cfg_q;
    logic [NUM_CELLS-1:0] drv_val;
    logic [NUM_CELLS-1:0] drv_en;

    pld_cfg_loader #(
        .NUM_CELLS(NUM_CELLS)
    ) u_loader (
        .clk    (clk),
        .por_n  (por_n),
        .load_en(cfg_load),
        .sdi    (cfg_sdi),
        .cfg_q  (cfg_q)
    );

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        mc_mode_e cell_mode;
        assign cell_mode = mc_mode_e'(cfg_q[2*gi +: 2]);

        pld_out_cell u_cell (
            .clk        (clk),
            .por_n      (por_n),
            .clr_term   (clr_term),
            .preset_term(preset_term),
            .sop        (sop[gi]),
            .oe         (oe[gi]),
            .mode       (cell_mode),
            .pin_in     (io_pin[gi]),
            .drv_val    (drv_val[gi]),
            .drv_en     (drv_en[gi]),
            .fb         (fb[gi])
        );

        assign io_pin[gi] = drv_en[gi] ? drv_val[gi] : 1'bz;
    end

endmodule

// File: tb/test_pld_macrocell_bank.sv
`timescale 1ns/1ps
module test_pld_macrocell_bank;

    localparam int N  = 4;
    localparam int CW = 2 * N;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          por_n, clr_term, preset_term, cfg_load, cfg_sdi;
    logic [N-1:0]  sop, oe, ext_en, ext_val, fb;
    wire  [N-1:0]  io_pin;

    for (genvar g = 0; g < N; g++) begin : g_ext
        assign io_pin[g] = ext_en[g] ? ext_val[g] : 1'bz;
    end

    pld_macrocell_bank #(.NUM_CELLS(N)) i_pld_macrocell_bank (
        .clk(clk), .por_n(por_n), .clr_term(clr_term), .preset_term(preset_term),
        .sop(sop), .oe(oe), .cfg_load(cfg_load), .cfg_sdi(cfg_sdi),
        .io_pin(io_pin), .fb(fb)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [CW-1:0] cfg_m;
    logic [N-1:0]  q_m;

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Expected pins and feedback from the requirements
    task automatic check_ports(input string tag);
        logic [N-1:0] ep, ef;
        for (int i = 0; i < N; i++) begin
            logic [1:0] m;
            logic d, dv;
            m  = cfg_m[2*i +: 2];
            d  = m[1] ? sop[i] : q_m[i];
            dv = m[0] ? d : ~d;
            ep[i] = oe[i] ? dv : ext_val[i];
            ef[i] = m[1] ? ep[i] : q_m[i];
        end
        chk(io_pin, ep, {tag, " pin"});
        chk(fb, ef, {tag, " fb"});
    endtask

    task automatic tick();
        @(posedge clk);
        if (clr_term)         q_m = '0;
        else if (preset_term) q_m = '1;
        else                  q_m = sop;
        @(negedge clk);
    endtask

    task automatic set_oe(input logic [N-1:0] o, input logic [N-1:0] ev);
        oe      = o;
        ext_en  = ~o;
        ext_val = ev;
    endtask

    task automatic t_reset();
        por_n = 1'b0; clr_term = 1'b0; preset_term = 1'b0;
        cfg_load = 1'b0; cfg_sdi = 1'b0;
        sop = 4'b1010;
        set_oe('1, '0);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        cfg_m = '1;
        q_m   = '0;
        #1 check_ports("R1 erased after reset");
        sop = 4'b0110;
        #1 check_ports("R1 R3 erased comb follows");
    endtask

    task automatic load_cfg(input logic [CW-1:0] nc);
        cfg_load = 1'b1;
        for (int b = 0; b < CW; b++) begin
            cfg_sdi = nc[b];
            tick();
            if (b == CW / 2) begin
                #1 check_ports("R9 old modes kept while shifting");
            end
        end
        cfg_load = 1'b0;
        #1 check_ports("R9 old modes before commit edge");
        tick();
        cfg_m = nc;
        #1 check_ports("R9 new modes after commit edge");
    endtask

    task automatic t_modes(input int rot);
        logic [CW-1:0] nc;
        logic [N-1:0]  pats [4];
        pats[0] = 4'b0000; pats[1] = 4'b1111; pats[2] = 4'b0110; pats[3] = 4'b1001;
        for (int i = 0; i < N; i++) nc[2*i +: 2] = 2'((i + rot) % 4);
        set_oe('1, '0);
        load_cfg(nc);
        for (int p = 0; p < 4; p++) begin
            sop = pats[p];
            #1 check_ports("R2 R3 before edge");
            tick();
            #1 check_ports("R2 R4 after edge");
            set_oe(4'b0101, pats[p] ^ 4'b1100);
            #1 check_ports("R5 R6 R4 pins released");
            set_oe(4'b1010, ~pats[p]);
            #1 check_ports("R5 R6 R4 other pins released");
            set_oe('1, '0);
        end
    endtask

    task automatic t_clear_preset();
        set_oe('1, '0);
        load_cfg({2'b00, 2'b01, 2'b00, 2'b01});
        sop = '1;
        tick();
        #1 check_ports("R2 flops loaded with ones");
        clr_term = 1'b1;
        q_m = '0;
        #0.5 check_ports("R7 clear without edge");
        preset_term = 1'b1;
        tick();
        #1 check_ports("R8 clear wins over preset");
        clr_term = 1'b0;
        sop = '0;
        tick();
        #1 check_ports("R8 preset sets flops");
        preset_term = 1'b0;
        tick();
        #1 check_ports("R2 capture after preset");
    endtask

    initial begin
        t_reset();
        for (int r = 0; r < 4; r++) t_modes(r);
        t_clear_preset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule